// File: doc/BRIEF.md
# Standby Wait-for-Interrupt/Event Controller

This block decides when a processor core's clock may be stopped after the core issues a wait-for-interrupt (WFI) or wait-for-event (WFE) hint, and when the clock must come back. A hint is not acted on until the memory system reports that outstanding transactions have drained. The core clock then goes off and the block watches a small set of wake inputs. WFI and WFE listen to different sets of inputs. Interrupt masks play no part in waking: any asserted interrupt line counts. A snoop request while the core is gated turns on only a separate coherency clock, and the core stays halted.

A one-bit pending-event flag records send-event broadcasts and timer events that arrive while the core is running. A WFE that finds the flag set clears it and returns at once, without gating. Every exit from standby, and the first cycle after reset, is reported by a one-cycle valid strobe together with a 3-bit cause code.

Top module: `standby_ctrl`

## Requirements
- R1: While `rst` is high, `core_clk_en` and `snoop_clk_en` are 1 and `in_standby` and `wake_valid` are 0. On the first clock edge after `rst` falls, `wake_valid` pulses for one cycle with `wake_cause` = 6 (reset).
- R2: A WFI hint sampled while `mem_idle` is high drops `core_clk_en` at the next edge. `in_standby` rises one edge later, so entry takes two cycles.
- R3: While `mem_idle` is low, a pending hint keeps `core_clk_en` high. Entry proceeds only once `mem_idle` is sampled high.
- R4: In WFI standby, any of `irq`, `fiq`, `async_abort` or `dbg_req` wakes the core. `in_standby` falls at the edge that samples the wake. One edge later `core_clk_en` returns, with `wake_valid` high for exactly one cycle.
- R5: In WFI standby, `sev_in` and `timer_evt` do not wake the core: `in_standby` stays 1 and `core_clk_en` stays 0.
- R6: In WFE standby, `sev_in` or `timer_evt` also wakes the core, reported with `wake_cause` = 1 (event).
- R7: `sev_in` or `timer_evt` while running sets a pending-event flag. A WFE sampled with the flag set leaves `core_clk_en` at 1 and `in_standby` at 0, and clears the flag, so the next WFE does gate.
- R8: When several wake inputs are present at once, the cause code follows the priority debug (5) > abort (4) > FIQ (3) > IRQ (2) > event (1). Code 0 is driven whenever `wake_valid` is low.
- R9: While the core is gated, `snoop_req` raises `snoop_clk_en` at the next edge, and `core_clk_en` stays 0 and `in_standby` stays 1. `snoop_clk_en` drops at the first edge that samples `snoop_req` low.
- R10: Asserting `rst` in standby restores `core_clk_en` and clears `in_standby` at the next edge.
- R11: WFI and WFE asserted together are treated as WFI, so events do not wake that standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| wfi_req | input | 1 | Wait-for-interrupt hint strobe |
| wfe_req | input | 1 | Wait-for-event hint strobe |
| mem_idle | input | 1 | Outstanding memory transactions drained |
| irq | input | 1 | Normal interrupt line (mask ignored) |
| fiq | input | 1 | Fast interrupt line (mask ignored) |
| async_abort | input | 1 | Asynchronous abort |
| dbg_req | input | 1 | External debug request |
| sev_in | input | 1 | Send-event broadcast from another core |
| timer_evt | input | 1 | Periodic timer event |
| snoop_req | input | 1 | Coherency snoop pending |
| core_clk_en | output | 1 | Enable for the core clock gate |
| snoop_clk_en | output | 1 | Enable for the coherency-logic clock gate |
| in_standby | output | 1 | Core is fully in standby |
| wake_valid | output | 1 | One-cycle strobe on standby exit or after reset |
| wake_cause | output | 3 | Cause code, meaningful while wake_valid is high |

## Verification
On every cycle the assertions check the following: the core clock is off whenever standby is reported, the clock never falls unless memory was idle, the wake strobe lasts one cycle and always carries a non-zero cause, reset restores the clock, and snoop activity while gated switches the coherency clock without waking the core. Only the directed scenarios can show which inputs wake which hint, the exact cause code chosen among simultaneous sources, the entry and exit cycle counts, and the pending-event flag being consumed by one WFE and then absent for the next.

// File: rtl/standby_pkg.sv
package standby_pkg;

    localparam int CAUSE_W = 3;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_DRAIN = 3'd1,
        ST_ENTER = 3'd2,
        ST_STBY  = 3'd3,
        ST_WAKE  = 3'd4
    } sb_state_e;

    typedef enum logic [CAUSE_W-1:0] {
        WC_NONE  = 3'd0,
        WC_EVENT = 3'd1,
        WC_IRQ   = 3'd2,
        WC_FIQ   = 3'd3,
        WC_ABORT = 3'd4,
        WC_DEBUG = 3'd5,
        WC_RESET = 3'd6
    } wake_cause_e;

    typedef struct packed {
        logic dbg;
        logic abort;
        logic fiq;
        logic irq;
        logic sev;
        logic timer;
    } wake_src_t;

    // Highest-ranked source wins; events count only in WFE mode.
    function automatic wake_cause_e rank_cause(wake_src_t s, logic wfe_mode, logic evt_pend);
        if (s.dbg)        return WC_DEBUG;
        else if (s.abort) return WC_ABORT;
        else if (s.fiq)   return WC_FIQ;
        else if (s.irq)   return WC_IRQ;
        else if (wfe_mode && (s.sev || s.timer || evt_pend)) return WC_EVENT;
        else              return WC_NONE;
    endfunction

endpackage

// File: rtl/sb_event_reg.sv
module sb_event_reg (
    input  logic clk,
    input  logic rst,
    input  logic evt_set,
    input  logic evt_clr,
    output logic evt_q
);
    // A new event on the same cycle as a consume is kept, not lost.
    always_ff @(posedge clk) begin
        if (rst)          evt_q <= 1'b0;
        else if (evt_set) evt_q <= 1'b1;
        else if (evt_clr) evt_q <= 1'b0;
    end
endmodule

// File: rtl/sb_wake_eval.sv
module sb_wake_eval
    import standby_pkg::*;
(
    input  wake_src_t   src,
    input  logic        wfe_mode,
    input  logic        evt_pend,
    output logic        wake,
    output wake_cause_e cause
);
    always_comb begin
        cause = rank_cause(src, wfe_mode, evt_pend);
        wake  = (cause != WC_NONE);
    end
endmodule

// File: rtl/sb_fsm.sv
module sb_fsm
    import standby_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wfi_req,
    input  logic        wfe_req,
    input  logic        mem_idle,
    input  logic        evt_q,
    input  logic        wake,
    input  wake_cause_e cause,
    input  logic        snoop_req,
    output logic        wfe_mode,
    output logic        evt_consume,
    output logic        core_clk_en,
    output logic        snoop_clk_en,
    output logic        in_standby,
    output logic        wake_valid,
    output logic [CAUSE_W-1:0] wake_cause
);
    sb_state_e   state_q, state_n;
    wake_cause_e held_cause_q;
    wake_cause_e out_cause_q;
    logic        mode_q;
    logic        snoop_q;
    logic        valid_q;
    logic        rst_flag_q;

    logic any_req, wfe_only, quick_ret, gated_n, listening;

    always_comb begin
        any_req   = wfi_req | wfe_req;
        wfe_only  = wfe_req & ~wfi_req;
        quick_ret = (state_q == ST_RUN) & wfe_only & evt_q;
        listening = (state_q == ST_ENTER) | (state_q == ST_STBY);
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_RUN:   if (any_req && !quick_ret) state_n = mem_idle ? ST_ENTER : ST_DRAIN;
            ST_DRAIN: if (mem_idle) state_n = ST_ENTER;
            ST_ENTER: state_n = wake ? ST_WAKE : ST_STBY;
            ST_STBY:  if (wake) state_n = ST_WAKE;
            ST_WAKE:  state_n = ST_RUN;
            default:  state_n = ST_RUN;
        endcase
        gated_n = (state_n == ST_ENTER) | (state_n == ST_STBY) | (state_n == ST_WAKE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_RUN;
            mode_q       <= 1'b0;
            held_cause_q <= WC_NONE;
            out_cause_q  <= WC_NONE;
            snoop_q      <= 1'b0;
            valid_q      <= 1'b0;
            rst_flag_q   <= 1'b1;
        end else begin
            state_q    <= state_n;
            rst_flag_q <= 1'b0;
            if (state_q == ST_RUN && any_req) mode_q <= wfe_only;
            if (listening && wake) held_cause_q <= cause;
            snoop_q <= snoop_req & gated_n;
            if (rst_flag_q) begin
                valid_q     <= 1'b1;
                out_cause_q <= WC_RESET;
            end else if (state_q == ST_WAKE) begin
                valid_q     <= 1'b1;
                out_cause_q <= held_cause_q;
            end else begin
                valid_q     <= 1'b0;
                out_cause_q <= WC_NONE;
            end
        end
    end

    always_comb begin
        wfe_mode     = mode_q;
        evt_consume  = quick_ret | (mode_q & listening & wake);
        core_clk_en  = (state_q == ST_RUN) | (state_q == ST_DRAIN);
        snoop_clk_en = core_clk_en | snoop_q;
        in_standby   = (state_q == ST_STBY);
        wake_valid   = valid_q;
        wake_cause   = out_cause_q;
    end
endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl
    import standby_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wfi_req,
    input  logic wfe_req,
    input  logic mem_idle,
    input  logic irq,
    input  logic fiq,
    input  logic async_abort,
    input  logic dbg_req,
    input  logic sev_in,
    input  logic timer_evt,
    input  logic snoop_req,
    output logic core_clk_en,
    output logic snoop_clk_en,
    output logic in_standby,
    output logic wake_valid,
    output logic [2:0] wake_cause
);
    wake_src_t   src;
    wake_cause_e cause;
    logic        wake, evt_q, wfe_mode, evt_consume;

    always_comb begin
        src.dbg   = dbg_req;
        src.abort = async_abort;
        src.fiq   = fiq;
        src.irq   = irq;
        src.sev   = sev_in;
        src.timer = timer_evt;
    end

    sb_event_reg u_evt (
        .clk     (clk),
        .rst     (rst),
        .evt_set (sev_in | timer_evt),
        .evt_clr (evt_consume),
        .evt_q   (evt_q)
    );

    sb_wake_eval u_eval (
        .src      (src),
        .wfe_mode (wfe_mode),
        .evt_pend (evt_q),
        .wake     (wake),
        .cause    (cause)
    );

    sb_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .wfi_req      (wfi_req),
        .wfe_req      (wfe_req),
        .mem_idle     (mem_idle),
        .evt_q        (evt_q),
        .wake         (wake),
        .cause        (cause),
        .snoop_req    (snoop_req),
        .wfe_mode     (wfe_mode),
        .evt_consume  (evt_consume),
        .core_clk_en  (core_clk_en),
        .snoop_clk_en (snoop_clk_en),
        .in_standby   (in_standby),
        .wake_valid   (wake_valid),
        .wake_cause   (wake_cause)
    );
endmodule

// File: rtl/standby_ctrl_chk.sv
module standby_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       mem_idle,
    input logic       snoop_req,
    input logic       core_clk_en,
    input logic       snoop_clk_en,
    input logic       in_standby,
    input logic       wake_valid,
    input logic [2:0] wake_cause
);
    AST_RESET_CLK_ON: assert property (@(posedge clk)
        rst |=> (core_clk_en && !in_standby)); // R10

    AST_STBY_CLK_OFF: assert property (@(posedge clk) disable iff (rst)
        in_standby |-> !core_clk_en); // R2

    AST_ENTER_THROUGH_GATE: assert property (@(posedge clk) disable iff (rst)
        $rose(in_standby) |-> $past(!core_clk_en)); // R2

    AST_DRAIN_BEFORE_GATE: assert property (@(posedge clk) disable iff (rst)
        $fell(core_clk_en) |-> $past(mem_idle)); // R3

    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        wake_valid |=> !wake_valid); // R4

    AST_CAUSE_NONZERO: assert property (@(posedge clk) disable iff (rst)
        wake_valid |-> (wake_cause != 3'd0)); // R8

    AST_CAUSE_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !wake_valid |-> (wake_cause == 3'd0)); // R8

    AST_SNOOP_CLK_UP: assert property (@(posedge clk) disable iff (rst)
        (!core_clk_en && snoop_req) |=> snoop_clk_en); // R9

    AST_SNOOP_NO_RESUME: assert property (@(posedge clk) disable iff (rst)
        (in_standby && !snoop_req) |=> !snoop_clk_en); // R9
endmodule

bind standby_ctrl standby_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .mem_idle     (mem_idle),
    .snoop_req    (snoop_req),
    .core_clk_en  (core_clk_en),
    .snoop_clk_en (snoop_clk_en),
    .in_standby   (in_standby),
    .wake_valid   (wake_valid),
    .wake_cause   (wake_cause)
);

// File: tb/standby_ctrl_tb.sv
module standby_ctrl_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wfi_req = 0, wfe_req = 0, mem_idle = 1, irq = 0, fiq = 0;
    logic async_abort = 0, dbg_req = 0, sev_in = 0, timer_evt = 0, snoop_req = 0;
    logic core_clk_en, snoop_clk_en, in_standby, wake_valid;
    logic [2:0] wake_cause;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    standby_ctrl u_dut (
        .clk(clk), .rst(rst), .wfi_req(wfi_req), .wfe_req(wfe_req), .mem_idle(mem_idle),
        .irq(irq), .fiq(fiq), .async_abort(async_abort), .dbg_req(dbg_req),
        .sev_in(sev_in), .timer_evt(timer_evt), .snoop_req(snoop_req),
        .core_clk_en(core_clk_en), .snoop_clk_en(snoop_clk_en), .in_standby(in_standby),
        .wake_valid(wake_valid), .wake_cause(wake_cause)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Issue a hint for one cycle with memory idle; verify two-cycle entry.
    task automatic enter(bit use_wfi, bit use_wfe);
        wfi_req = use_wfi;
        wfe_req = use_wfe;
        step();
        wfi_req = 0;
        wfe_req = 0;
        chk("R2 clk off after hint", core_clk_en, 0);
        chk("R2 not yet standby", in_standby, 0);
        step();
        chk("R2 standby reached", in_standby, 1);
    endtask

    // Caller has set wake inputs; check exit timing and the cause code.
    task automatic expect_exit(string tag, int cause);
        step();
        irq = 0; fiq = 0; async_abort = 0; dbg_req = 0; sev_in = 0; timer_evt = 0;
        chk({tag, " standby left"}, in_standby, 0);
        chk({tag, " clk still off"}, core_clk_en, 0);
        step();
        chk({tag, " R4 clk back"}, core_clk_en, 1);
        chk({tag, " R4 valid"}, wake_valid, 1);
        chk({tag, " cause"}, wake_cause, cause);
        step();
        chk({tag, " R4 valid one cycle"}, wake_valid, 0);
    endtask

    task automatic t_reset();
        step();
        chk("R1 clk on in reset", core_clk_en, 1);
        chk("R1 snoop clk on in reset", snoop_clk_en, 1);
        chk("R1 no standby in reset", in_standby, 0);
        chk("R1 no valid in reset", wake_valid, 0);
        rst = 0;
        step();
        chk("R1 reset valid", wake_valid, 1);
        chk("R1 reset cause", wake_cause, 6);
        step();
        chk("R1 reset valid drops", wake_valid, 0);
    endtask

    task automatic t_wfi_sources();
        enter(1, 0); irq = 1;         expect_exit("R4 irq", 2);
        enter(1, 0); fiq = 1;         expect_exit("R4 fiq", 3);
        enter(1, 0); async_abort = 1; expect_exit("R4 abort", 4);
        enter(1, 0); dbg_req = 1;     expect_exit("R4 debug", 5);
    endtask

    task automatic t_priority();
        enter(1, 0);
        irq = 1; fiq = 1; async_abort = 1; dbg_req = 1;
        expect_exit("R8 all", 5);
        enter(1, 0);
        irq = 1; fiq = 1; async_abort = 1;
        expect_exit("R8 abort over fiq", 4);
        enter(1, 0);
        irq = 1; fiq = 1;
        expect_exit("R8 fiq over irq", 3);
        enter(0, 1);
        irq = 1; sev_in = 1;
        expect_exit("R8 irq over event", 2);
    endtask

    task automatic t_drain();
        mem_idle = 0;
        wfi_req = 1;
        step();
        wfi_req = 0;
        for (int i = 0; i < 3; i++) begin
            chk("R3 clk held while busy", core_clk_en, 1);
            step();
        end
        chk("R3 no standby while busy", in_standby, 0);
        mem_idle = 1;
        step();
        chk("R3 gate after idle", core_clk_en, 0);
        step();
        chk("R3 standby after idle", in_standby, 1);
        irq = 1;
        expect_exit("R3 exit", 2);
    endtask

    task automatic t_wfi_ignores_events();
        enter(1, 0);
        sev_in = 1;
        step();
        sev_in = 0;
        timer_evt = 1;
        step();
        timer_evt = 0;
        step();
        chk("R5 still standby", in_standby, 1);
        chk("R5 clk still off", core_clk_en, 0);
        irq = 1;
        expect_exit("R5 exit", 2);
    endtask

    task automatic t_quick_return();
        // Flag was set by the previous scenario; a WFE consumes it.
        wfe_req = 1;
        step();
        wfe_req = 0;
        chk("R7 no gating", core_clk_en, 1);
        step();
        chk("R7 no standby", in_standby, 0);
        chk("R7 no valid", wake_valid, 0);
        enter(0, 1);
        chk("R7 flag was cleared", in_standby, 1);
        timer_evt = 1;
        expect_exit("R6 timer", 1);
        sev_in = 1;
        step();
        sev_in = 0;
        step();
        wfe_req = 1;
        step();
        wfe_req = 0;
        chk("R7 sev then wfe returns", core_clk_en, 1);
        step();
    endtask

    task automatic t_wfe_sev();
        enter(0, 1);
        step();
        chk("R6 waits", in_standby, 1);
        sev_in = 1;
        expect_exit("R6 sev", 1);
    endtask

    task automatic t_snoop();
        enter(1, 0);
        chk("R9 snoop clk off", snoop_clk_en, 0);
        snoop_req = 1;
        step();
        chk("R9 snoop clk on", snoop_clk_en, 1);
        chk("R9 core stays off", core_clk_en, 0);
        step();
        chk("R9 still standby", in_standby, 1);
        snoop_req = 0;
        step();
        chk("R9 snoop clk off again", snoop_clk_en, 0);
        chk("R9 standby kept", in_standby, 1);
        dbg_req = 1;
        expect_exit("R9 exit", 5);
    endtask

    task automatic t_both();
        enter(1, 1);
        sev_in = 1;
        step();
        sev_in = 0;
        step();
        chk("R11 events ignored", in_standby, 1);
        fiq = 1;
        expect_exit("R11 exit", 3);
        wfe_req = 1;  // drain the flag set above
        step();
        wfe_req = 0;
        step();
    endtask

    task automatic t_reset_in_standby();
        enter(1, 0);
        rst = 1;
        step();
        chk("R10 clk restored", core_clk_en, 1);
        chk("R10 standby cleared", in_standby, 0);
        rst = 0;
        step();
        chk("R10 reset cause", wake_cause, 6);
        step();
    endtask

    initial begin
        t_reset();
        t_wfi_sources();
        t_priority();
        t_drain();
        t_wfi_ignores_events();
        t_quick_return();
        t_wfe_sev();
        t_snoop();
        t_both();
        t_reset_in_standby();
        done = 1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule